// File: doc/BRIEF.md
# Block Cipher Mode Controller

This controller sits between a message stream and a single-block 128-bit cipher engine. It turns the engine into a confidentiality mode: electronic codebook, cipher block chaining, cipher feedback with a selectable segment width, output feedback, or counter. It keeps the 128-bit chaining value. That value is first loaded as an initialization vector, one 32-bit word at a time, and the controller then updates it after every block as the selected mode requires.

Message blocks go into a two-slot input buffer. While the engine works on the block at the head, the next block can already be written. Each finished block is presented on a held output register with a valid flag, and the consumer acknowledges it with a read strobe. The controller does not launch a new block while a result is still waiting to be read.

For message authentication, a last-output option hides every result except the one for the block flagged as final. A chained CBC run then yields only the tag. The engine handles key scheduling itself and reports readiness on `key_ready`.

Top module: `cipher_mode_ctrl`

## Requirements
- R1: After reset `out_valid`, `in_full` and `core_start` are 0 and no block runs until input is written.
- R2: ECB (`cfg_mode`=0): the output is the engine result for the input block. The engine direction follows `cfg_decrypt` (1 = decrypt).
- R3: CBC (`cfg_mode`=1): on encryption the engine gets input XOR chain, and the result is both the output and the new chain. On decryption the output is the engine's decrypt result XOR chain, and the new chain is the ciphertext input.
- R4: CFB (`cfg_mode`=2): `cfg_seg` selects an s-bit segment (0:8, 1:16, 2:32, 3:64, 4 and above:128) held in the most significant s bits of the block. The output is (input XOR E(chain)) in those bits and zero below them. The chain shifts left by s and takes in the ciphertext segment.
- R5: OFB (`cfg_mode`=3): the output is input XOR E(chain), and E(chain) becomes the new chain.
- R6: CTR (`cfg_mode`=4): the output is input XOR E(chain), and the chain then increments by 1 modulo 2^128. In CFB, OFB and CTR the engine always runs in the encrypt direction.
- R7: IV word k (`iv_idx`=k) fills chain bits [127-32k:96-32k]. A block in a mode other than ECB starts only once all four words have been written since reset. No block starts while `key_ready` is 0.
- R8: The buffer holds two blocks, and `in_full` is 1 while it holds two. A write while full is dropped and never produces output.
- R9: `out_valid` rises when a result is stored and falls the cycle after `out_rd`. `out_block` stays stable while valid, and no new block starts while a result is unread.
- R10: With `cfg_last_only`=1, only a block written with `in_last`=1 raises `out_valid`. Earlier blocks still update the chain.
- R11: Each block issues a one-cycle `core_start`, with `core_decrypt` equal to `cfg_decrypt` in ECB and CBC and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Mode: 0 ECB, 1 CBC, 2 CFB, 3 OFB, 4 CTR |
| cfg_decrypt | input | 1 | 1 = decrypt message |
| cfg_seg | input | 3 | CFB segment width code |
| cfg_last_only | input | 1 | Show only the final block's result |
| key_ready | input | 1 | Engine key is set up |
| iv_wr | input | 1 | IV word write strobe |
| iv_idx | input | 2 | IV word index, 0 = most significant |
| iv_word | input | 32 | IV word value |
| in_wr | input | 1 | Input block write strobe |
| in_block | input | 128 | Input block |
| in_last | input | 1 | Marks the final block of a message |
| in_full | output | 1 | Both input slots occupied |
| core_start | output | 1 | Engine start pulse |
| core_decrypt | output | 1 | Engine direction |
| core_din | output | 128 | Engine input block |
| core_done | input | 1 | Engine result ready pulse |
| core_dout | input | 128 | Engine result |
| out_valid | output | 1 | Result pending |
| out_block | output | 128 | Result block |
| out_rd | input | 1 | Result acknowledge |

## Verification
The assertions assume that the configuration inputs and `key_ready` stay constant while a block is in the engine. They also assume that IV words are written only while no block is running, and that the engine returns exactly one `core_done` for each `core_start`. The bench changes mode, segment width, direction and IV only while the controller is idle with no result pending. Its stand-in engine is a fixed-latency invertible permutation that answers every start once.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [2:0] {
    M_ECB = 3'd0,
    M_CBC = 3'd1,
    M_CFB = 3'd2,
    M_OFB = 3'd3,
    M_CTR = 3'd4
  } mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctl_st_e;

  // Segment width in bits for a CFB width code, capped at the block width.
  function automatic int seg_len_of(input logic [2:0] code, input int blk);
    int n;
    case (code)
      3'd0:    n = 8;
      3'd1:    n = 16;
      3'd2:    n = 32;
      3'd3:    n = 64;
      default: n = blk;
    endcase
    return (n > blk) ? blk : n;
  endfunction

  // Modes whose engine pass always runs forward.
  function automatic logic is_stream(input mode_e m);
    return (m == M_CFB) || (m == M_OFB) || (m == M_CTR);
  endfunction
endpackage

// File: rtl/cmc_in_buf.sv
module cmc_in_buf #(
  parameter int W     = 128,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         wr_last,
  input  logic         rd_en,
  output logic [W-1:0] head_data,
  output logic         head_last,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [DEPTH-1:0] last_q;
  logic [PW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  assign head_data = mem_q[rptr_q];
  assign head_last = last_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_wr) wptr_d = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
    if (do_rd) rptr_d = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = do_wr && (wptr_q == PW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q[gi] <= 1'b0;
      end else if (slot_we) begin
        last_q[gi] <= wr_last;
      end
    end
    always_ff @(posedge clk) begin
      if (slot_we) mem_q[gi] <= wr_data;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (full && $stable(wptr_q))); // R8
endmodule

// File: rtl/cmc_chain.sv
module cmc_chain #(
  parameter int BLK  = 128,
  parameter int WORD = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 iv_we,
  input  logic [$clog2(BLK/WORD)-1:0]          iv_idx,
  input  logic [WORD-1:0]                      iv_word,
  input  logic                                 upd_en,
  input  logic [BLK-1:0]                       upd_val,
  output logic [BLK-1:0]                       chain_q,
  output logic                                 iv_ok
);
  localparam int NW    = BLK / WORD;
  localparam int IDX_W = $clog2(NW);

  wire  [BLK-1:0] chain_d;
  logic [NW-1:0]  seen_q, seen_d;

  for (genvar gi = 0; gi < NW; gi++) begin : g_word
    localparam int HI = BLK - 1 - gi * WORD;
    logic hit;
    assign hit = iv_we && (iv_idx == IDX_W'(gi));
    assign chain_d[HI -: WORD] = upd_en ? upd_val[HI -: WORD]
                               : (hit ? iv_word : chain_q[HI -: WORD]);
    assign seen_d[gi] = seen_q[gi] | (hit && !upd_en);
  end

  assign iv_ok = &seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      seen_q  <= '0;
    end else begin
      chain_q <= chain_d;
      seen_q  <= seen_d;
    end
  end

  AST_IV_WORD_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_we && !upd_en && iv_idx == '0) |=> (chain_q[BLK-1 -: WORD] == $past(iv_word))); // R7
endmodule

// File: rtl/cmc_mode_dp.sv
module cmc_mode_dp
  import cmc_pkg::*;
#(
  parameter int BLK = 128
) (
  input  mode_e          mode,
  input  logic           dec,
  input  logic [2:0]     seg_code,
  input  logic [BLK-1:0] data,
  input  logic [BLK-1:0] chain,
  input  logic [BLK-1:0] core_res,
  output logic [BLK-1:0] core_din,
  output logic           core_dec,
  output logic [BLK-1:0] out_val,
  output logic [BLK-1:0] chain_nxt
);
  localparam int SW = $clog2(BLK) + 1;

  logic [SW-1:0]  seg_len;
  logic [BLK-1:0] seg_mask, fb_out, fb_ct, ks_xor;

  assign seg_len  = SW'(seg_len_of(seg_code, BLK));
  assign seg_mask = ~({BLK{1'b1}} >> seg_len);
  assign ks_xor   = data ^ core_res;
  assign fb_out   = ks_xor & seg_mask;
  assign fb_ct    = dec ? (data & seg_mask) : fb_out;

  always_comb begin
    core_din  = chain;
    core_dec  = 1'b0;
    out_val   = ks_xor;
    chain_nxt = chain;
    case (mode)
      M_CBC: begin
        core_dec = dec;
        if (dec) begin
          core_din  = data;
          out_val   = core_res ^ chain;
          chain_nxt = data;
        end else begin
          core_din  = data ^ chain;
          out_val   = core_res;
          chain_nxt = core_res;
        end
      end
      M_CFB: begin
        out_val   = fb_out;
        chain_nxt = (chain << seg_len) | (fb_ct >> (SW'(BLK) - seg_len));
      end
      M_OFB: begin
        chain_nxt = core_res;
      end
      M_CTR: begin
        chain_nxt = chain + BLK'(1);
      end
      default: begin
        core_din = data;
        core_dec = dec;
        out_val  = core_res;
      end
    endcase
  end
endmodule

// File: rtl/cipher_mode_ctrl.sv
module cipher_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int BLK   = 128,
  parameter int WORD  = 32,
  parameter int DEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  cfg_mode,
  input  logic                        cfg_decrypt,
  input  logic [2:0]                  cfg_seg,
  input  logic                        cfg_last_only,
  input  logic                        key_ready,
  input  logic                        iv_wr,
  input  logic [$clog2(BLK/WORD)-1:0] iv_idx,
  input  logic [WORD-1:0]             iv_word,
  input  logic                        in_wr,
  input  logic [BLK-1:0]              in_block,
  input  logic                        in_last,
  output logic                        in_full,
  output logic                        core_start,
  output logic                        core_decrypt,
  output logic [BLK-1:0]              core_din,
  input  logic                        core_done,
  input  logic [BLK-1:0]              core_dout,
  output logic                        out_valid,
  output logic [BLK-1:0]              out_block,
  input  logic                        out_rd
);
  mode_e          mode;
  ctl_st_e        st_q, st_d;
  logic [BLK-1:0] head_data, chain_q, chain_nxt, out_val, out_q, out_d;
  logic           head_last, buf_empty, iv_ok, needs_iv;
  logic           start_ok, done_evt, show, vld_q, vld_d;

  assign mode     = mode_e'(cfg_mode);
  assign needs_iv = (mode == M_CBC) || is_stream(mode);
  assign start_ok = (st_q == ST_IDLE) && !buf_empty && key_ready &&
                    (!needs_iv || iv_ok) && !vld_q;
  assign done_evt = (st_q == ST_RUN) && core_done;
  assign show     = done_evt && (!cfg_last_only || head_last);

  cmc_in_buf #(.W(BLK), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (in_wr),
    .wr_data   (in_block),
    .wr_last   (in_last),
    .rd_en     (done_evt),
    .head_data (head_data),
    .head_last (head_last),
    .empty     (buf_empty),
    .full      (in_full)
  );

  cmc_chain #(.BLK(BLK), .WORD(WORD)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .iv_we   (iv_wr && (st_q == ST_IDLE)),
    .iv_idx  (iv_idx),
    .iv_word (iv_word),
    .upd_en  (done_evt && (mode != M_ECB) && needs_iv),
    .upd_val (chain_nxt),
    .chain_q (chain_q),
    .iv_ok   (iv_ok)
  );

  cmc_mode_dp #(.BLK(BLK)) u_dp (
    .mode      (mode),
    .dec       (cfg_decrypt),
    .seg_code  (cfg_seg),
    .data      (head_data),
    .chain     (chain_q),
    .core_res  (core_dout),
    .core_din  (core_din),
    .core_dec  (core_decrypt),
    .out_val   (out_val),
    .chain_nxt (chain_nxt)
  );

  assign core_start = start_ok;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_ok)  st_d = ST_RUN;
      default: if (core_done) st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    vld_d = vld_q;
    out_d = out_q;
    if (show) begin
      vld_d = 1'b1;
      out_d = out_val;
    end else if (out_rd) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      vld_q <= 1'b0;
      out_q <= '0;
    end else begin
      st_q  <= st_d;
      vld_q <= vld_d;
      out_q <= out_d;
    end
  end

  assign out_valid = vld_q;
  assign out_block = out_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start); // R11
  AST_STREAM_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && cfg_mode inside {3'd2, 3'd3, 3'd4}) |-> !core_decrypt); // R6
  AST_START_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !out_valid); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_rd) |=> (out_valid && $stable(out_block))); // R9
  AST_OUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rd) |=> !out_valid); // R9
  AST_IV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && cfg_mode != 3'd0) |-> iv_ok); // R7
  AST_KEY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> key_ready); // R7
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && cfg_mode == 3'd4) |=> (chain_q == $past(chain_q) + BLK'(1))); // R6
endmodule

// File: tb/tb_cipher_mode_ctrl.sv
package tb_perm_pkg;
  localparam logic [127:0] PKEY = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

  function automatic logic [127:0] p_enc(input logic [127:0] x);
    logic [127:0] t;
    t = x ^ PKEY;
    return {t[120:0], t[127:121]};
  endfunction

  function automatic logic [127:0] p_dec(input logic [127:0] y);
    logic [127:0] t;
    t = {y[6:0], y[127:7]};
    return t ^ PKEY;
  endfunction
endpackage

module tb_cipher_stub #(parameter int LAT = 3) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         dec,
  input  logic [127:0] din,
  output logic         done,
  output logic [127:0] dout
);
  import tb_perm_pkg::*;
  int cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= 0;
      done <= 1'b0;
      dout <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt  <= LAT;
        dout <= dec ? p_dec(din) : p_enc(din);
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) done <= 1'b1;
      end
    end
  end
endmodule

module tb_cipher_mode_ctrl;
  import tb_perm_pkg::*;

  logic         clk;
  logic         rst_n;
  logic [2:0]   cfg_mode, cfg_seg;
  logic         cfg_decrypt, cfg_last_only, key_ready;
  logic         iv_wr;
  logic [1:0]   iv_idx;
  logic [31:0]  iv_word;
  logic         in_wr, in_last, in_full;
  logic [127:0] in_block;
  logic         core_start, core_decrypt, core_done;
  logic [127:0] core_din, core_dout;
  logic         out_valid, out_rd;
  logic [127:0] out_block;

  int n_tests = 0;
  int n_fail  = 0;
  int starts  = 0;
  logic [127:0] m_chain;

  cipher_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_decrypt(cfg_decrypt),
    .cfg_seg(cfg_seg), .cfg_last_only(cfg_last_only), .key_ready(key_ready),
    .iv_wr(iv_wr), .iv_idx(iv_idx), .iv_word(iv_word), .in_wr(in_wr),
    .in_block(in_block), .in_last(in_last), .in_full(in_full),
    .core_start(core_start), .core_decrypt(core_decrypt), .core_din(core_din),
    .core_done(core_done), .core_dout(core_dout), .out_valid(out_valid),
    .out_block(out_block), .out_rd(out_rd)
  );

  tb_cipher_stub #(.LAT(3)) u_core (
    .clk(clk), .rst_n(rst_n), .start(core_start), .dec(core_decrypt),
    .din(core_din), .done(core_done), .dout(core_dout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Every clock: count engine launches and check the direction (R11).
  always @(negedge clk) begin
    if (rst_n && core_start) begin
      starts++;
      check("R11 direction", {127'd0, core_decrypt},
            {127'd0, (cfg_mode <= 3'd1) ? cfg_decrypt : 1'b0});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // Behavioural reference for one block; updates the model chain.
  task automatic model_step(input logic [127:0] d, output logic [127:0] exp);
    logic [127:0] r, msk, c;
    int s;
    case (cfg_mode)
      3'd1: begin
        if (!cfg_decrypt) begin exp = p_enc(d ^ m_chain); m_chain = exp; end
        else begin exp = p_dec(d) ^ m_chain; m_chain = d; end
      end
      3'd2: begin
        case (cfg_seg) 3'd0: s = 8; 3'd1: s = 16; 3'd2: s = 32; 3'd3: s = 64; default: s = 128; endcase
        r = p_enc(m_chain);
        msk = '0;
        for (int b = 0; b < s; b++) msk[127 - b] = 1'b1;
        exp = (d ^ r) & msk;
        c = cfg_decrypt ? (d & msk) : exp;
        if (s == 128) m_chain = c;
        else m_chain = (m_chain << s) | (c >> (128 - s));
      end
      3'd3: begin r = p_enc(m_chain); exp = d ^ r; m_chain = r; end
      3'd4: begin r = p_enc(m_chain); exp = d ^ r; m_chain = m_chain + 128'd1; end
      default: exp = cfg_decrypt ? p_dec(d) : p_enc(d);
    endcase
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic dcr, input logic [2:0] sg, input logic lo);
    cfg_mode = m; cfg_decrypt = dcr; cfg_seg = sg; cfg_last_only = lo;
    @(negedge clk);
  endtask

  task automatic load_iv(input logic [127:0] v);
    for (int k = 0; k < 4; k++) begin
      iv_wr = 1'b1; iv_idx = 2'(k); iv_word = v[127 - 32*k -: 32];
      @(negedge clk);
    end
    iv_wr = 1'b0;
    m_chain = v;
  endtask

  task automatic push_raw(input logic [127:0] d, input logic l);
    in_wr = 1'b1; in_block = d; in_last = l;
    @(negedge clk);
    in_wr = 1'b0;
  endtask

  task automatic push(input logic [127:0] d, input logic l);
    while (in_full) @(negedge clk);
    push_raw(d, l);
  endtask

  task automatic expect_out(input string req, input logic [127:0] exp);
    int t = 0;
    while (!out_valid && t < 200) begin @(negedge clk); t++; end
    check(req, out_block, exp);
    out_rd = 1'b1;
    @(negedge clk);
    out_rd = 1'b0;
  endtask

  task automatic run_one(input string req, input logic [127:0] d, output logic [127:0] got);
    logic [127:0] e;
    model_step(d, e);
    push(d, 1'b0);
    expect_out(req, e);
    got = e;
  endtask

  initial begin
    logic [127:0] pa, pb, ca, cb, e1, e2, e3, tmp;
    int s0, t;
    rst_n = 1'b0; cfg_mode = 3'd0; cfg_decrypt = 1'b0; cfg_seg = 3'd0;
    cfg_last_only = 1'b0; key_ready = 1'b0; iv_wr = 1'b0; iv_idx = '0;
    iv_word = '0; in_wr = 1'b0; in_block = '0; in_last = 1'b0; out_rd = 1'b0;
    m_chain = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid", {127'd0, out_valid}, 128'd0);
    check("R1 in_full", {127'd0, in_full}, 128'd0);
    check("R1 core_start", {127'd0, core_start}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: CBC waits for the IV
    key_ready = 1'b1;
    set_cfg(3'd1, 1'b0, 3'd0, 1'b0);
    pa = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    pb = 128'hDEADBEEF_01234567_89ABCDEF_FEDCBA98;
    push(pa, 1'b0);
    repeat (20) @(negedge clk);
    check("R7 no start without IV", {96'd0, 32'(starts), out_valid}, 128'd0);
    load_iv(128'hA5A5A5A5_5A5A5A5A_12345678_9ABCDEF0);
    model_step(pa, ca);
    expect_out("R3 CBC enc block 1", ca);
    run_one("R3 CBC enc block 2", pb, cb);

    // R3: CBC decrypt recovers plaintext
    set_cfg(3'd1, 1'b1, 3'd0, 1'b0);
    load_iv(128'hA5A5A5A5_5A5A5A5A_12345678_9ABCDEF0);
    run_one("R3 CBC dec block 1", ca, tmp);
    check("R3 CBC dec plaintext 1", tmp, pa);
    run_one("R3 CBC dec block 2", cb, tmp);
    check("R3 CBC dec plaintext 2", tmp, pb);

    // R2: ECB both directions
    set_cfg(3'd0, 1'b0, 3'd0, 1'b0);
    run_one("R2 ECB enc", pa, tmp);
    check("R2 ECB enc value", tmp, p_enc(pa));
    set_cfg(3'd0, 1'b1, 3'd0, 1'b0);
    run_one("R2 ECB dec", pb, tmp);

    // R4: CFB for every segment width
    for (int sc = 0; sc < 5; sc++) begin
      set_cfg(3'd2, 1'b0, 3'(sc), 1'b0);
      load_iv(128'h0BADF00D_CAFEBABE_13579BDF_2468ACE0);
      run_one("R4 CFB enc 1", pa, ca);
      run_one("R4 CFB enc 2", pb, cb);
      set_cfg(3'd2, 1'b1, 3'(sc), 1'b0);
      load_iv(128'h0BADF00D_CAFEBABE_13579BDF_2468ACE0);
      run_one("R4 CFB dec 1", ca, e1);
      run_one("R4 CFB dec 2", cb, e2);
      check("R4 CFB round trip", e2, pb & ~({128{1'b1}} >> (sc == 4 ? 128 : (8 << sc))));
    end

    // R5: OFB
    set_cfg(3'd3, 1'b0, 3'd0, 1'b0);
    load_iv(128'h11111111_22222222_33333333_44444444);
    run_one("R5 OFB 1", pa, tmp);
    run_one("R5 OFB 2", pb, tmp);

    // R6: CTR with counter wrap
    set_cfg(3'd4, 1'b1, 3'd0, 1'b0);
    load_iv({128{1'b1}});
    run_one("R6 CTR at all ones", pa, tmp);
    run_one("R6 CTR wrapped", pb, tmp);
    check("R6 CTR wrap value", tmp, pb ^ p_enc(128'd0));

    // R9: no launch while a result is unread
    set_cfg(3'd0, 1'b0, 3'd0, 1'b0);
    model_step(pa, e1);
    model_step(pb, e2);
    push(pa, 1'b0);
    t = 0;
    while (!out_valid && t < 200) begin @(negedge clk); t++; end
    s0 = starts;
    push(pb, 1'b0);
    repeat (10) @(negedge clk);
    check("R9 no start while pending", 128'(starts), 128'(s0));
    check("R9 held output", out_block, e1);
    expect_out("R9 first result", e1);
    expect_out("R9 second result", e2);

    // R8 and R7: double buffer, drop when full, key gating
    key_ready = 1'b0;
    @(negedge clk);
    push_raw(pa, 1'b0);
    push_raw(pb, 1'b0);
    check("R8 full after two", {127'd0, in_full}, 128'd1);
    push_raw(128'h77777777_77777777_77777777_77777777, 1'b0);
    check("R8 still full", {127'd0, in_full}, 128'd1);
    s0 = starts;
    repeat (10) @(negedge clk);
    check("R7 no start without key", 128'(starts), 128'(s0));
    key_ready = 1'b1;
    model_step(pa, e1);
    model_step(pb, e2);
    expect_out("R8 buffered 1", e1);
    expect_out("R8 buffered 2", e2);
    repeat (20) @(negedge clk);
    check("R8 dropped write", {126'd0, out_valid, in_full}, 128'd0);

    // R10: CBC-MAC with last-output only
    set_cfg(3'd1, 1'b0, 3'd0, 1'b1);
    load_iv(128'd0);
    model_step(pa, e1);
    model_step(pb, e2);
    model_step(128'h31415926_53589793_23846264_33832795, e3);
    push(pa, 1'b0);
    push(pb, 1'b0);
    push(128'h31415926_53589793_23846264_33832795, 1'b1);
    expect_out("R10 MAC tag", e3);
    repeat (20) @(negedge clk);
    check("R10 single output", {127'd0, out_valid}, 128'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule